// File: doc/BRIEF.md
# Sector Protect Pulse Sequencer

This block runs the write-protect and write-unprotect procedure for a single flash sector from the controller side. A one-cycle request carries an operation (lock or unlock) and a sector number. The block then drives a simple bus master port through repeated attempts. Each attempt is an arming write of 60h, a timed high-voltage pulse, a verify command of 40h and a read of the sector's lock status. It stops when the verify passes or when the attempt budget for that operation runs out, and it reports a one-cycle done or fail pulse.

Unlocking needs every sector to be locked first. An unlock request therefore first walks all sectors in ascending order and locks each one, with a fresh attempt budget per sector. Only after that does it pulse the requested sector toward unlocked. The high-voltage supply is abstracted as one enable output. Pulse lengths are given in microseconds and converted to clock cycles from the clock frequency and a scaling divisor.

Top module: `sector_guard_seq`

## Requirements
- R1: After reset, busy, done, fail, the high-voltage enable and both bus strobes are low.
- R2: Each attempt starts with one bus write of data 60h. Its address carries the current sector in bits [SECT_W:1] and the operation in bit 0 (0 = lock, 1 = unlock).
- R3: The verify command write follows the arming write by exactly pulse+1 cycles. The pulse is LOCK_US*CLK_MHZ/PULSE_DIV cycles for a lock and UNLOCK_US*CLK_MHZ/PULSE_DIV cycles for an unlock, with a minimum of 1. The bus is idle during the pulse.
- R4: Verify writes data 40h to the same address. The next cycle issues a read strobe at that address, and the read data is taken in the cycle after the strobe.
- R5: A lock attempt passes when bit 0 of the read data is 1, and an unlock attempt passes when bit 0 is 0. All other read bits are ignored.
- R6: The attempt count starts at 1 for each sector and rises by one after every failed verify. A lock that fails LOCK_LIMIT attempts raises fail.
- R7: An unlock that fails UNLOCK_LIMIT attempts (default 1000) raises fail.
- R8: An unlock request first locks sectors 0 to NUM_SECT-1 in ascending order, then unlocks the requested sector. A lock failure during that walk ends the request with fail.
- R9: The high-voltage enable is high from the first arming write until the last verify check of the request. It is high during every bus strobe and low in the done or fail cycle.
- R10: Busy rises in the cycle after an accepted request and stays high through a one-cycle done or fail pulse, never both. A request that arrives while busy has no effect on the bus or the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, sampled while idle |
| unlock_i | input | 1 | 0 = lock request, 1 = unlock request |
| sector_i | input | SECT_W | Target sector |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| hv_en_o | output | 1 | High-voltage supply enable |
| bus_addr_o | output | SECT_W+1 | {sector, operation bit} |
| bus_wdata_o | output | DATA_W | Write data (60h arm, 40h verify) |
| bus_wr_o | output | 1 | Write strobe |
| bus_rd_o | output | 1 | Read strobe |
| bus_rdata_i | input | DATA_W | Read data, valid the cycle after the read strobe |

## Verification
Two functions can fall in the same cycle: a passing verify check that ends the lock walk, and the handover of the walk to the unlock of the target sector. In that cycle the sector pointer, the operation bit and the attempt count all change together. The bench provokes this with an unlock request where some sectors need several lock pulses. It then judges the exact order of verify addresses, each pulse gap per operation, and the total latency in cycles. A second collision is a new request in the middle of a run. The bench judges it by showing that no bus access ever names the second request's sector and that exactly one done pulse appears.

// File: rtl/sps_pkg.sv
package sps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ARM,
      ST_PULSE,
      ST_VCMD,
      ST_VREAD,
      ST_VCHK,
      ST_END_OK,
      ST_END_BAD
   } seq_state_t;

   typedef enum logic {
      OP_LOCK   = 1'b0,
      OP_UNLOCK = 1'b1
   } seq_op_t;

   localparam logic [7:0] CMD_ARM    = 8'h60;
   localparam logic [7:0] CMD_VERIFY = 8'h40;

endpackage

// File: rtl/sps_pulse_timer.sv
module sps_pulse_timer #(
   parameter int LOCK_CYC   = 30000,
   parameter int UNLOCK_CYC = 3000000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   input  logic unlock_i,
   output logic run_o,
   output logic expire_o
);
   localparam int MAX_CYC = (LOCK_CYC > UNLOCK_CYC) ? LOCK_CYC : UNLOCK_CYC;
   localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (LOCK_CYC < 1 || UNLOCK_CYC < 1) begin : g_bad_len
         $error("pulse lengths must be at least one cycle");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= unlock_i ? CNT_W'(UNLOCK_CYC - 1) : CNT_W'(LOCK_CYC - 1);
         run_q <= 1'b1;
      end else if (run_q) begin
         if (cnt_q == '0) run_q <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end

   assign run_o    = run_q;
   assign expire_o = run_q && (cnt_q == '0);

   assert_count_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (int'(cnt_q) < MAX_CYC));

   assert_load_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> !run_q);

endmodule

// File: rtl/sps_try_counter.sv
module sps_try_counter #(
   parameter int LOCK_LIMIT   = 25,
   parameter int UNLOCK_LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart_i,
   input  logic bump_i,
   input  logic unlock_i,
   output logic at_limit_o
);
   localparam int MAX_LIM = (LOCK_LIMIT > UNLOCK_LIMIT) ? LOCK_LIMIT : UNLOCK_LIMIT;
   localparam int TRY_W   = $clog2(MAX_LIM + 1);

   generate
      if (LOCK_LIMIT < 1 || UNLOCK_LIMIT < 1) begin : g_bad_lim
         $error("attempt limits must be at least one");
      end
   endgenerate

   logic [TRY_W-1:0] tries_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         tries_q <= TRY_W'(1);
      else if (restart_i) tries_q <= TRY_W'(1);
      else if (bump_i)    tries_q <= tries_q + 1'b1;
   end

   assign at_limit_o = unlock_i ? (int'(tries_q) >= UNLOCK_LIMIT)
                                : (int'(tries_q) >= LOCK_LIMIT);

   assert_try_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tries_q != '0) && (int'(tries_q) <= MAX_LIM));

   assert_no_bump_at_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bump_i |-> !at_limit_o);

endmodule

// File: rtl/sps_sector_walker.sv
module sps_sector_walker #(
   parameter int NUM_SECT = 16,
   parameter int SECT_W   = $clog2(NUM_SECT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic              unlock_i,
   input  logic [SECT_W-1:0] target_i,
   input  logic              advance_i,
   output logic [SECT_W-1:0] cur_o,
   output logic              walking_o,
   output logic              op_unlock_o
);
   import sps_pkg::*;

   localparam logic [SECT_W-1:0] LAST = SECT_W'(NUM_SECT - 1);

   generate
      if (NUM_SECT < 2 || (1 << SECT_W) < NUM_SECT) begin : g_bad_sect
         $error("sector count and address width disagree");
      end
   endgenerate

   logic [SECT_W-1:0] target_q;
   logic [SECT_W-1:0] cur_q;
   logic              walk_q;
   seq_op_t           op_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         target_q <= '0;
         cur_q    <= '0;
         walk_q   <= 1'b0;
         op_q     <= OP_LOCK;
      end else if (load_i) begin
         target_q <= target_i;
         op_q     <= unlock_i ? OP_UNLOCK : OP_LOCK;
         walk_q   <= unlock_i;
         cur_q    <= unlock_i ? '0 : target_i;
      end else if (advance_i && walk_q) begin
         if (cur_q == LAST) begin
            walk_q <= 1'b0;
            cur_q  <= target_q;
         end else begin
            cur_q <= cur_q + 1'b1;
         end
      end
   end

   assign cur_o       = cur_q;
   assign walking_o   = walk_q;
   assign op_unlock_o = !walk_q && (op_q == OP_UNLOCK);

   assert_walk_ascends_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (walk_q && $past(walk_q) && !$past(load_i) && (cur_q != $past(cur_q)))
         |-> (cur_q == $past(cur_q) + 1'b1));

   assert_walk_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      walk_q |-> (int'(cur_q) < NUM_SECT));

endmodule

// File: rtl/sector_guard_seq.sv
module sector_guard_seq #(
   parameter int NUM_SECT     = 16,
   parameter int SECT_W       = $clog2(NUM_SECT),
   parameter int DATA_W       = 16,
   parameter int CLK_MHZ      = 200,
   parameter int PULSE_DIV    = 1,
   parameter int LOCK_US      = 150,
   parameter int UNLOCK_US    = 15000,
   parameter int LOCK_LIMIT   = 25,
   parameter int UNLOCK_LIMIT = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              unlock_i,
   input  logic [SECT_W-1:0] sector_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o,
   output logic              hv_en_o,
   output logic [SECT_W:0]   bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic              bus_wr_o,
   output logic              bus_rd_o,
   input  logic [DATA_W-1:0] bus_rdata_i
);
   import sps_pkg::*;

   localparam int LOCK_RAW   = (LOCK_US * CLK_MHZ) / PULSE_DIV;
   localparam int UNLOCK_RAW = (UNLOCK_US * CLK_MHZ) / PULSE_DIV;
   localparam int LOCK_CYC   = (LOCK_RAW < 1) ? 1 : LOCK_RAW;
   localparam int UNLOCK_CYC = (UNLOCK_RAW < 1) ? 1 : UNLOCK_RAW;

   generate
      if (DATA_W < 8) begin : g_bad_data
         $error("data width must hold an 8-bit command");
      end
      if (PULSE_DIV < 1 || CLK_MHZ < 1) begin : g_bad_clk
         $error("clock scaling must be positive");
      end
   endgenerate

   seq_state_t        state_q, state_d;
   logic [SECT_W-1:0] cur_sect;
   logic              walking;
   logic              op_unlock;
   logic              pulse_run;
   logic              pulse_end;
   logic              at_limit;
   logic              verify_ok;
   logic              accept;
   logic              walk_step;
   logic              try_restart;
   logic              try_bump;

   assign accept    = (state_q == ST_IDLE) && start_i;
   assign verify_ok = op_unlock ? !bus_rdata_i[0] : bus_rdata_i[0];
   assign walk_step = (state_q == ST_VCHK) && verify_ok && walking;
   assign try_restart = accept || walk_step;
   assign try_bump  = (state_q == ST_VCHK) && !verify_ok && !at_limit;

   sps_sector_walker #(
      .NUM_SECT (NUM_SECT),
      .SECT_W   (SECT_W)
   ) u_walker (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_i      (accept),
      .unlock_i    (unlock_i),
      .target_i    (sector_i),
      .advance_i   (walk_step),
      .cur_o       (cur_sect),
      .walking_o   (walking),
      .op_unlock_o (op_unlock)
   );

   sps_pulse_timer #(
      .LOCK_CYC   (LOCK_CYC),
      .UNLOCK_CYC (UNLOCK_CYC)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (state_q == ST_ARM),
      .unlock_i (op_unlock),
      .run_o    (pulse_run),
      .expire_o (pulse_end)
   );

   sps_try_counter #(
      .LOCK_LIMIT   (LOCK_LIMIT),
      .UNLOCK_LIMIT (UNLOCK_LIMIT)
   ) u_tries (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart_i  (try_restart),
      .bump_i     (try_bump),
      .unlock_i   (op_unlock),
      .at_limit_o (at_limit)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:    if (start_i) state_d = ST_ARM;
         ST_ARM:     state_d = ST_PULSE;
         ST_PULSE:   if (pulse_end) state_d = ST_VCMD;
         ST_VCMD:    state_d = ST_VREAD;
         ST_VREAD:   state_d = ST_VCHK;
         ST_VCHK: begin
            if (verify_ok)     state_d = walking ? ST_ARM : ST_END_OK;
            else if (at_limit) state_d = ST_END_BAD;
            else               state_d = ST_ARM;
         end
         ST_END_OK:  state_d = ST_IDLE;
         ST_END_BAD: state_d = ST_IDLE;
         default:    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign done_o      = (state_q == ST_END_OK);
   assign fail_o      = (state_q == ST_END_BAD);
   assign hv_en_o     = (state_q == ST_ARM) || (state_q == ST_PULSE) ||
                        (state_q == ST_VCMD) || (state_q == ST_VREAD) ||
                        (state_q == ST_VCHK);
   assign bus_addr_o  = {cur_sect, op_unlock};
   assign bus_wdata_o = DATA_W'((state_q == ST_ARM) ? CMD_ARM : CMD_VERIFY);
   assign bus_wr_o    = (state_q == ST_ARM) || (state_q == ST_VCMD);
   assign bus_rd_o    = (state_q == ST_VREAD);

   assert_single_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({done_o, fail_o}));

   assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !done_o && !fail_o) |=> busy_o);

   assert_result_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |=> !busy_o);

   assert_hv_on_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_o || bus_rd_o) |-> hv_en_o);

   assert_quiet_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_run |-> (!bus_wr_o && !bus_rd_o && hv_en_o));

   assert_read_follows_verify_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rd_o) |-> ($past(bus_wr_o) && $stable(bus_addr_o)));

endmodule

// File: tb/sector_guard_seq_bench.sv
module sector_guard_seq_bench;

   localparam int NS     = 4;
   localparam int SW     = 2;
   localparam int DW     = 16;
   localparam int P_CYC  = 3;    // 150*200/10000
   localparam int U_CYC  = 300;  // 15000*200/10000
   localparam int P_LIM  = 25;
   localparam int U_LIM  = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic          unlock_i = 1'b0;
   logic [SW-1:0] sector_i = '0;
   logic          busy_o, done_o, fail_o, hv_en_o, bus_wr_o, bus_rd_o;
   logic [SW:0]   bus_addr_o;
   logic [DW-1:0] bus_wdata_o;
   logic [DW-1:0] bus_rdata_i = '0;

   always #2.5 clk = ~clk;

   sector_guard_seq #(
      .NUM_SECT (NS), .SECT_W (SW), .DATA_W (DW), .CLK_MHZ (200),
      .PULSE_DIV (10000), .LOCK_US (150), .UNLOCK_US (15000),
      .LOCK_LIMIT (P_LIM), .UNLOCK_LIMIT (U_LIM)
   ) u_sector_guard_seq (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .unlock_i (unlock_i),
      .sector_i (sector_i), .busy_o (busy_o), .done_o (done_o), .fail_o (fail_o),
      .hv_en_o (hv_en_o), .bus_addr_o (bus_addr_o), .bus_wdata_o (bus_wdata_o),
      .bus_wr_o (bus_wr_o), .bus_rd_o (bus_rd_o), .bus_rdata_i (bus_rdata_i)
   );

   int total = 0;
   int bad   = 0;

   // behavioural flash status model
   logic       locked [NS];
   int         need_l [NS];
   int         need_u [NS];
   int         cnt_l  [NS];
   int         cnt_u  [NS];
   logic [SW:0] vlog  [64];
   int         nlog;
   int         cyc = 0;
   int         err_arm, err_gap, err_ver, err_hv, n_done;
   logic       armed = 1'b0;
   logic [SW:0] arm_addr;
   int         arm_cyc;
   logic       last_vw = 1'b0;
   logic [SW:0] last_va;

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (done_o) n_done = n_done + 1;
      if (bus_rd_o) begin
         if (!hv_en_o) err_hv = err_hv + 1;
         if (!last_vw || bus_addr_o != last_va) err_ver = err_ver + 1;
         bus_rdata_i <= {15'h7FFF, locked[bus_addr_o[SW:1]]};
      end
      last_vw = 1'b0;
      if (bus_wr_o) begin
         if (!hv_en_o) err_hv = err_hv + 1;
         if (bus_wdata_o == 16'h0060) begin
            if (armed) err_arm = err_arm + 1;
            armed = 1'b1; arm_addr = bus_addr_o; arm_cyc = cyc;
         end else if (bus_wdata_o == 16'h0040) begin
            automatic int s = int'(bus_addr_o[SW:1]);
            if (!armed || bus_addr_o != arm_addr) err_ver = err_ver + 1;
            if (cyc - arm_cyc != (bus_addr_o[0] ? U_CYC + 1 : P_CYC + 1)) err_gap = err_gap + 1;
            armed = 1'b0; last_vw = 1'b1; last_va = bus_addr_o;
            if (nlog < 64) vlog[nlog] = bus_addr_o;
            nlog = nlog + 1;
            if (bus_addr_o[0]) begin
               cnt_u[s] = cnt_u[s] + 1;
               if (need_u[s] != 0 && cnt_u[s] >= need_u[s]) locked[s] = 1'b0;
            end else begin
               cnt_l[s] = cnt_l[s] + 1;
               if (need_l[s] != 0 && cnt_l[s] >= need_l[s]) locked[s] = 1'b1;
            end
         end else begin
            err_arm = err_arm + 1;
         end
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic setup_model(input logic [NS-1:0] lk, input int nl, input int nu);
      for (int i = 0; i < NS; i++) begin
         locked[i] = lk[i]; need_l[i] = nl; need_u[i] = nu; cnt_l[i] = 0; cnt_u[i] = 0;
      end
      nlog = 0; err_arm = 0; err_gap = 0; err_ver = 0; err_hv = 0; n_done = 0;
   endtask

   // returns negedges from request to result, and 1 for done / 2 for fail
   task automatic run_req(input bit unl, input int sect, output int lat, output int res);
      @(negedge clk);
      start_i = 1'b1; unlock_i = unl; sector_i = SW'(sect);
      @(negedge clk);
      start_i = 1'b0;
      check(busy_o, "R10 busy after request", busy_o, 1);
      lat = 1;
      while (!(done_o || fail_o)) begin
         check(!(done_o && fail_o), "R10 single result", 1, 0);
         @(negedge clk);
         lat = lat + 1;
      end
      res = done_o ? 1 : 2;
      check(!hv_en_o, "R9 hv low at result", hv_en_o, 0);
      @(negedge clk);
      check(!busy_o && !done_o && !fail_o, "R10 idle after pulse", busy_o, 0);
   endtask

   task automatic check_model(input string tag);
      check(err_arm == 0, {tag, " R2 arm writes"}, err_arm, 0);
      check(err_gap == 0, {tag, " R3 pulse gap"}, err_gap, 0);
      check(err_ver == 0, {tag, " R4 verify order"}, err_ver, 0);
      check(err_hv == 0, {tag, " R9 hv during strobes"}, err_hv, 0);
   endtask

   task automatic t_reset;
      check(!busy_o && !done_o && !fail_o, "R1 reset status", busy_o, 0);
      check(!hv_en_o && !bus_wr_o && !bus_rd_o, "R1 reset bus", hv_en_o, 0);
   endtask

   task automatic t_lock_first_try;
      int lat, res;
      setup_model(4'b0000, 1, 0);
      run_req(1'b0, 2, lat, res);
      check(res == 1, "R5 lock passes on bit0=1", res, 1);
      check(lat == P_CYC + 5, "R3 single attempt latency", lat, P_CYC + 5);
      check(nlog == 1 && vlog[0] == 3'b100, "R2 address sector2 lock", int'(vlog[0]), 4);
      check(locked[2] == 1'b1, "R5 sector2 locked", locked[2], 1);
      check_model("lock1");
   endtask

   task automatic t_lock_retry;
      int lat, res;
      setup_model(4'b0000, 3, 0);
      run_req(1'b0, 1, lat, res);
      check(res == 1, "R6 lock after retries", res, 1);
      check(nlog == 3, "R6 three attempts", nlog, 3);
      check(lat == 3 * (P_CYC + 4) + 1, "R6 retry latency", lat, 3 * (P_CYC + 4) + 1);
      check_model("lock3");
   endtask

   task automatic t_lock_fail;
      int lat, res;
      setup_model(4'b0000, 0, 0);
      run_req(1'b0, 3, lat, res);
      check(res == 2, "R6 lock limit fail", res, 2);
      check(nlog == P_LIM, "R6 attempts at limit", nlog, P_LIM);
      check(lat == P_LIM * (P_CYC + 4) + 1, "R6 fail latency", lat, P_LIM * (P_CYC + 4) + 1);
      check_model("lockfail");
   endtask

   task automatic t_unlock_walk;
      int lat, res;
      logic [SW:0] exp_seq [8];
      exp_seq = '{3'b000, 3'b010, 3'b010, 3'b100, 3'b110, 3'b101, 3'b101, 3'b101};
      setup_model(4'b0101, 0, 0);
      need_l[1] = 2; need_l[3] = 1; need_u[2] = 3;
      run_req(1'b1, 2, lat, res);
      check(res == 1, "R8 unlock done", res, 1);
      check(nlog == 8, "R8 attempt count", nlog, 8);
      for (int i = 0; i < 8; i++)
         check(vlog[i] == exp_seq[i], "R8 verify order", int'(vlog[i]), int'(exp_seq[i]));
      check(lat == 5 * (P_CYC + 4) + 3 * (U_CYC + 4) + 1, "R3 R8 walk latency",
            lat, 5 * (P_CYC + 4) + 3 * (U_CYC + 4) + 1);
      check(locked[2] == 1'b0 && locked[1] && locked[3], "R5 final lock state", locked[2], 0);
      check_model("walk");
   endtask

   task automatic t_unlock_fail;
      int lat, res;
      setup_model(4'b1111, 0, 0);
      run_req(1'b1, 0, lat, res);
      check(res == 2, "R7 unlock limit fail", res, 2);
      check(nlog == NS + U_LIM, "R7 attempts", nlog, NS + U_LIM);
      check(lat == NS * (P_CYC + 4) + U_LIM * (U_CYC + 4) + 1, "R7 fail latency",
            lat, NS * (P_CYC + 4) + U_LIM * (U_CYC + 4) + 1);
      check_model("unlockfail");
   endtask

   task automatic t_ignored_start;
      int lat, bad_sect;
      setup_model(4'b0000, 2, 0);
      @(negedge clk);
      start_i = 1'b1; unlock_i = 1'b0; sector_i = 2'd1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (2) @(negedge clk);
      start_i = 1'b1; unlock_i = 1'b1; sector_i = 2'd3;
      @(negedge clk);
      start_i = 1'b0;
      lat = 0;
      while (!(done_o || fail_o) && lat < 1000) begin
         @(negedge clk);
         lat = lat + 1;
      end
      check(done_o, "R10 first request completes", done_o, 1);
      repeat (20) @(negedge clk);
      check(!busy_o, "R10 second request dropped", busy_o, 0);
      check(n_done == 1, "R10 one done pulse", n_done, 1);
      bad_sect = 0;
      for (int i = 0; i < nlog && i < 64; i++) if (vlog[i] != 3'b010) bad_sect++;
      check(nlog == 2 && bad_sect == 0, "R10 no access from ignored request", bad_sect, 0);
      check_model("ignore");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      setup_model(4'b0000, 1, 0);
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lock_first_try();
      t_lock_retry();
      t_lock_fail();
      t_unlock_walk();
      t_unlock_fail();
      t_ignored_start();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule